// File: doc/BRIEF.md
# Highest-Line Encoder with Two-Digit Decimal Result

This block watches a bank of request lines, numbered from 1 upward, and names the highest-numbered line that is currently raised. The result is shown as a two-digit packed decimal (BCD) value on an 8-bit bus. A separate one-bit flag tells whether any line is raised at all. The block is purely combinational. It has no clock and no storage, and every input pattern gives a defined output.

A typical use is to drive a pair of decimal digit displays that show which input has the highest rank. It also suits status logic that must report the top pending source as a number a person can read. The flag lets downstream logic tell the value 00 for "nothing raised" apart from a real line number, since line numbers start at 1.

Top module: `prio_bcd_enc`

## Requirements
- R1: The block has 16 request inputs, each active when at logic 1. Input bit k carries line number k+1, so bit 0 is line 1 and bit 15 is line 16.
- R2: When exactly one line is raised, the output equals that line's number in packed BCD.
- R3: When several lines are raised, the output reports the highest-numbered raised line.
- R4: When no line is raised, the 8-bit output is 0000_0000.
- R5: The flag output is 1 when at least one line is raised and 0 when none is.
- R6: Bits [7:4] carry the tens digit and bits [3:0] carry the units digit. Each nibble is a valid decimal digit (0 to 9). Lines 1 to 9 give a tens digit of 0. Lines 10 to 16 give a tens digit of 1 and a units digit of 0 to 6.
- R7: While a higher line is raised, changes on any lower-numbered line have no effect on either output.
- R8: With lines 5 and 16 both raised, the output is 0001_0110 (decimal 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 16 | Request levels; bit k is line k+1, active high |
| bcd_o | output | 8 | Highest raised line number as packed BCD, tens digit in [7:4] |
| any_o | output | 1 | High when at least one request line is raised |

## Verification
The built-in checks assume that every request bit is a known 0 or 1. They also assume the checks run once the combinational paths have settled after an input change. If a bit were unknown or floating, the highest-line search would have no defined answer. To respect both assumptions, the stimulus drives whole two-state request words, and only on the falling clock edge. The results are read on the following rising edge, well after every input has settled.

// File: rtl/prio_bcd_pkg.sv
package prio_bcd_pkg;

    // default size of the request bank
    localparam int unsigned LINES_DEF  = 16;
    // default count of decimal digits in the result
    localparam int unsigned DIGITS_DEF = 2;

    typedef logic [3:0] dec_digit_t;

endpackage

// File: rtl/prio_line_scan.sv
// Finds the highest raised request line and returns its 1-based number.
module prio_line_scan #(
    parameter int unsigned LINES = 16,
    localparam int unsigned NUMW = $clog2(LINES + 1)
) (
    input  logic [LINES-1:0] req_i,
    output logic [NUMW-1:0]  num_o,
    output logic             hit_o
);

    always_comb begin
        num_o = '0;
        hit_o = 1'b0;
        // ascending walk: the last raised bit seen is the highest one
        for (int k = 0; k < int'(LINES); k++) begin
            if (req_i[k]) begin
                num_o = NUMW'(k + 1);
                hit_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_bin2dec.sv
// Shift-and-add-three conversion of an unsigned binary value to packed BCD.
module prio_bin2dec #(
    parameter int unsigned BW  = 5,
    parameter int unsigned DIG = 2,
    localparam int unsigned OW = 4 * DIG
) (
    input  logic [BW-1:0] bin_i,
    output logic [OW-1:0] dec_o
);

    always_comb begin
        logic [OW-1:0] acc;
        acc = '0;
        for (int b = int'(BW) - 1; b >= 0; b--) begin
            for (int d = 0; d < int'(DIG); d++) begin
                if (acc[4*d +: 4] >= 4'd5) begin
                    acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
                end
            end
            acc = {acc[OW-2:0], bin_i[b]};
        end
        dec_o = acc;
    end

endmodule

// File: rtl/prio_bcd_enc.sv
// Top: highest raised line reported as packed decimal digits plus a flag.
module prio_bcd_enc
    import prio_bcd_pkg::*;
#(
    parameter int unsigned LINES  = LINES_DEF,
    parameter int unsigned DIGITS = DIGITS_DEF,
    localparam int unsigned NUMW  = $clog2(LINES + 1),
    localparam int unsigned OUTW  = 4 * DIGITS
) (
    input  logic [LINES-1:0] req_i,
    output logic [OUTW-1:0]  bcd_o,
    output logic             any_o
);

    logic [NUMW-1:0] win_num;
    logic            win_hit;
    logic [OUTW-1:0] win_dec;

    prio_line_scan #(
        .LINES (LINES)
    ) u_scan (
        .req_i (req_i),
        .num_o (win_num),
        .hit_o (win_hit)
    );

    prio_bin2dec #(
        .BW  (NUMW),
        .DIG (DIGITS)
    ) u_conv (
        .bin_i (win_num),
        .dec_o (win_dec)
    );

    assign bcd_o = win_dec;
    assign any_o = win_hit;

    // checks on the settled combinational result
    always_comb begin
        // R5
        any_flag_chk: assert (any_o == (req_i != '0))
            else $error("flag disagrees with request bank");
        // R4
        none_zero_chk: assert (any_o || (bcd_o == '0))
            else $error("non-zero result with no request");
        // R3
        above_clear_chk: assert (!win_hit || ((req_i >> win_num) == '0))
            else $error("a higher line is raised than the one reported");
        // R2
        winner_set_chk: assert (!win_hit || (((req_i >> (win_num - NUMW'(1))) & LINES'(1)) != '0))
            else $error("reported line is not raised");
    end

    for (genvar g = 0; g < int'(DIGITS); g++) begin : g_digit_chk
        dec_digit_t dig;
        assign dig = bcd_o[4*g +: 4];
        always_comb begin
            // R6
            digit_range_chk: assert (dig <= 4'd9)
                else $error("digit out of decimal range");
        end
    end

endmodule

// File: tb/prio_bcd_enc_tb.sv
module prio_bcd_enc_tb;

    logic        clk;
    logic        rst_n;
    logic [15:0] req;
    logic [7:0]  bcd;
    logic        any;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int cycles = 0;

    prio_bcd_enc u_dut (
        .req_i (req),
        .bcd_o (bcd),
        .any_o (any)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // {request, expected bcd, expected flag}
    localparam int NV = 13;
    localparam logic [24:0] VEC [NV] = '{
        {16'h0000, 8'h00, 1'b0},
        {16'h0001, 8'h01, 1'b1},
        {16'h8000, 8'h16, 1'b1},
        {16'h8010, 8'h16, 1'b1},
        {16'h0200, 8'h10, 1'b1},
        {16'h0100, 8'h09, 1'b1},
        {16'h0300, 8'h10, 1'b1},
        {16'hFFFF, 8'h16, 1'b1},
        {16'h7FFF, 8'h15, 1'b1},
        {16'h00FF, 8'h08, 1'b1},
        {16'h1234, 8'h13, 1'b1},
        {16'h0A00, 8'h12, 1'b1},
        {16'h0421, 8'h11, 1'b1}
    };

    function automatic logic [7:0] model_bcd(input logic [15:0] r);
        int n = 0;
        for (int k = 15; k >= 0; k--) begin
            if (r[k] && n == 0) n = k + 1;
        end
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic check(input string tag, input logic [7:0] eb, input logic ea);
        total++;
        if (bcd !== eb || any !== ea) begin
            bad++;
            $display("FAIL %s req=%h got bcd=%h any=%b exp bcd=%h any=%b",
                     tag, req, bcd, any, eb, ea);
        end
    endtask

    task automatic apply(input logic [15:0] r);
        @(negedge clk);
        req = r;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lf;
        logic [7:0]  hold;
        req   = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // reset state: idle bank (R4, R5)
        check("R4 R5 reset idle", 8'h00, 1'b0);
        rst_n = 1'b1;

        // vector table (R2 R3 R6 R8)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][24:9]);
            check("R3 R6 R8 table", VEC[i][8:1], VEC[i][0]);
        end

        // single-line sweep: bit k is line k+1 (R1 R2 R6)
        for (int k = 0; k < 16; k++) begin
            apply(16'(1) << k);
            check("R1 R2 single", {4'((k + 1) / 10), 4'((k + 1) % 10)}, 1'b1);
        end

        // lower lines ignored while line 13 raised (R7)
        apply(16'h1000);
        hold = bcd;
        for (int j = 0; j < 12; j++) begin
            apply(16'h1000 | (16'h0FFF ^ (16'(1) << j)));
            check("R7 lower ignored", 8'h13, 1'b1);
        end
        if (hold !== 8'h13) begin
            total++; bad++;
            $display("FAIL R7 base got=%h exp=13", hold);
        end

        // explicit example (R8)
        apply(16'h8010);
        check("R8 lines 5 and 16", 8'h16, 1'b1);

        // back to idle (R4)
        apply(16'h0000);
        check("R4 idle again", 8'h00, 1'b0);

        // pseudo-random multi-line patterns (R3 R5)
        lf = 16'hACE1;
        for (int t = 0; t < 200; t++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply(lf >> (t % 16));
            check("R3 R5 random", model_bcd(req), req != 16'h0);
        end

        finish_run();
    end

endmodule